// File: doc/BRIEF.md
# Power-Rail Control Byte Receiver (I2C Write Slave)

This block is a write-only I2C target that owns one control byte. A bus master addresses it at a single fixed 7-bit address and sends one data byte. That byte is latched into a register whose bits switch individual power regulators and high-side drivers on or off. One further bit picks the output level of a dual-voltage rail. Read transfers are never acknowledged.

SCL and SDA come from the pads as plain logic levels. They are brought into the system clock domain by two-flop synchronizers, and all protocol decisions are taken on edges of the synchronized copies. The acknowledge is driven as an open-drain pull-down enable, `sda_oe`. The register moves only after a data byte has been received in full and its acknowledge clock has ended. A START or STOP that arrives inside a byte throws the transfer away.

Top module: `rail_ctl_i2c`

## Requirements
- R1: After synchronous reset every rail and driver output is 0, `rail4_hi` is 0 (low setting), and `sda_oe` is 0.
- R2: An address byte equal to 0x10 (7-bit address 0001000, then write bit 0) is acknowledged: the line is held low during the ninth SCL high phase.
- R3: Any other address byte, including 0x11 (a read of the same address), is not acknowledged. The data byte that follows is neither acknowledged nor stored.
- R4: After a matching address, the data byte is acknowledged on its ninth clock, and `sda_oe` returns to 0 within a quarter SCL period after that ninth clock falls.
- R5: Bytes arrive MSB first and map as follows: bit7 `rail1_en`, bit6 `rail4_en`, bit5 `rail4_hi` (0 = low 8 V setting, 1 = high 10 V setting), bit4 `rail5_en`, bit3 `drv1_en`, bit2 `drv2_en`, bit1 `drv3_en`. Bit0 is ignored.
- R6: The outputs keep their old value throughout the data byte and its ACK high phase. They change only after the ninth SCL falls, and only while SCL is low.
- R7: A STOP (SDA rising while SCL is high) or a repeated START (SDA falling while SCL is high) inside a data byte leaves the outputs unchanged.
- R8: A START is recognised in any state, so a complete write that follows an aborted one takes effect.
- R9: Bytes after the first data byte of a transfer are not acknowledged and are not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad (wired-AND line) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| rail1_en | output | 1 | Enable for regulator 1 |
| rail4_en | output | 1 | Enable for the dual-voltage regulator |
| rail4_hi | output | 1 | Voltage select of the dual-voltage regulator, 1 = high |
| rail5_en | output | 1 | Enable for regulator 5 |
| drv1_en | output | 1 | Enable for high-side driver 1 |
| drv2_en | output | 1 | Enable for high-side driver 2 |
| drv3_en | output | 1 | Enable for high-side driver 3 |

## Verification
Every result has a fixed due point. An SCL edge reaches the protocol engine two system clocks after the pin moves, the engine reacts on the next clock, and the register one clock after that. So `sda_oe` asserts three clocks after the eighth SCL fall, and the outputs move four clocks after the ninth SCL fall. The bench waits a quarter SCL period (eight system clocks) after each bus edge before it samples, so every result has settled. It reads the ACK in the middle of the ninth high phase, when it also confirms that the outputs still hold the old value. It checks the `sda_oe` release a quarter period after the ninth fall, and the register contents a quarter period after STOP.

// File: rtl/rail_ctl_pkg.sv
// Shared types and constants for the rail control byte receiver.
package rail_ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // Receive engine states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;
endpackage

// File: rtl/rail_ctl_sync.sv
// Multi-bit synchronizer with edge detection.
// Each input bit goes through its own STAGES-deep flop chain plus one
// extra flop for edge detect. Assumes inputs idle high (open-drain bus).
module rail_ctl_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chan
            logic [STAGES:0] chain;

            // Shift the pad level through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-1:0], din[g]};
            end

            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
            assign fall[g] = ~chain[STAGES-1] & chain[STAGES];
        end
    endgenerate
endmodule

// File: rtl/rail_ctl_buscond.sv
// Detects bus START and STOP conditions from synchronized SCL/SDA.
// Assumes both lines pass through identical synchronizer depth.
module rail_ctl_buscond (
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_det,
    output logic stop_det
);
    // An SDA edge while SCL is high is a bus condition, not data
    always_comb begin
        start_det = scl_lvl & sda_fall;
        stop_det  = scl_lvl & sda_rise;
    end
endmodule

// File: rtl/rail_ctl_rx.sv
// Byte receive engine: shifts address and data bytes MSB first,
// drives ACK for a matching write address and for the first data byte,
// and pulses wr_en once the data byte's acknowledge clock has ended.
// Assumes SCL low phases last more than three system clocks.
module rail_ctl_rx
    import rail_ctl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [BYTE_W-1:0] ADDR_BYTE = {SLAVE_ADDR, 1'b0};
    localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(BYTE_W);

    rx_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic              oe_q;
    logic              wr_q;

    // Protocol sequencing, bit shifting and ACK drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shreg_q <= '0;
            oe_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (start_det) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else if (stop_det) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && cnt_q != FULL_CNT) begin
                            shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl};
                            cnt_q   <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == FULL_CNT) begin
                            if (state_q == ST_DATA) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_DATA_ACK;
                            end else if (shreg_q == ADDR_BYTE) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_SKIP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_DATA;
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            oe_q    <= 1'b0;
                            wr_q    <= 1'b1;
                            state_q <= ST_SKIP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign wr_en   = wr_q;
    assign wr_data = shreg_q;
endmodule

// File: rtl/rail_ctl_reg.sv
// Control byte register. Loads the masked write data on wr_en and
// resets to all-off.
module rail_ctl_reg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q
);
    // Hold the control byte, loading only the meaningful bits
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wr_data & MASK;
    end
endmodule

// File: rtl/rail_ctl_i2c.sv
// Top level: write-only bus target holding one power-rail control byte.
// Assumes clk runs at least 20 times faster than SCL.
module rail_ctl_i2c
    import rail_ctl_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h08,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    output logic rail1_en,
    output logic rail4_en,
    output logic rail4_hi,
    output logic rail5_en,
    output logic drv1_en,
    output logic drv2_en,
    output logic drv3_en
);
    localparam int                NSIG     = 2;
    localparam int                IDX_SCL  = 1;
    localparam int                IDX_SDA  = 0;
    localparam logic [BYTE_W-1:0] USE_MASK = 8'hFE;

    logic [NSIG-1:0]   s_lvl, s_rise, s_fall;
    logic              start_det, stop_det;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] ctrl_q;

    rail_ctl_sync #(.N(NSIG), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    rail_ctl_buscond u_cond (
        .scl_lvl  (s_lvl[IDX_SCL]),
        .sda_rise (s_rise[IDX_SDA]),
        .sda_fall (s_fall[IDX_SDA]),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    rail_ctl_rx #(.SLAVE_ADDR(SLAVE_ADDR)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (s_rise[IDX_SCL]),
        .scl_fall (s_fall[IDX_SCL]),
        .sda_lvl  (s_lvl[IDX_SDA]),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_data  (wr_data)
    );

    rail_ctl_reg #(.W(BYTE_W), .MASK(USE_MASK)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .ctrl_q (ctrl_q)
    );

    // Bit positions are fixed by the bus byte layout
    assign rail1_en = ctrl_q[7];
    assign rail4_en = ctrl_q[6];
    assign rail4_hi = ctrl_q[5];
    assign rail5_en = ctrl_q[4];
    assign drv1_en  = ctrl_q[3];
    assign drv2_en  = ctrl_q[2];
    assign drv3_en  = ctrl_q[1];
endmodule

// File: rtl/rail_ctl_chk.sv
// Protocol checker bound to rail_ctl_i2c. Observes ports only.
module rail_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic rail1_en,
    input logic rail4_en,
    input logic rail4_hi,
    input logic rail5_en,
    input logic drv1_en,
    input logic drv2_en,
    input logic drv3_en
);
    logic [6:0] outs;
    logic       rst_prev_q;

    assign outs = {rail1_en, rail4_en, rail4_hi, rail5_en, drv1_en, drv2_en, drv3_en};

    // Remember the previous reset level to find the release edge
    always_ff @(posedge clk) rst_prev_q <= rst_n;

    // Outputs are all off when reset is released
    always_ff @(posedge clk) begin
        if (rst_n && rst_prev_q == 1'b0)
            p_reset_off_r1: assert (outs == '0 && !sda_oe)
                else $error("outputs not cleared by reset");
    end

    // ACK drive changes only while SCL is low
    p_oe_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // Outputs change only while SCL is low
    p_out_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(outs) |-> !scl_i);

    // Outputs change only right after an acknowledge was released
    p_out_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(outs) |-> ($past(sda_oe, 2) && !$past(sda_oe)));
endmodule

bind rail_ctl_i2c rail_ctl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .sda_oe  (sda_oe),
    .rail1_en(rail1_en),
    .rail4_en(rail4_en),
    .rail4_hi(rail4_hi),
    .rail5_en(rail5_en),
    .drv1_en (drv1_en),
    .drv2_en (drv2_en),
    .drv3_en (drv3_en)
);

// File: tb/tb_rail_ctl_i2c.sv
module tb_rail_ctl_i2c;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;
    localparam int WATCHDOG   = 150000;
    localparam int NRAND      = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic rail1_en, rail4_en, rail4_hi, rail5_en, drv1_en, drv2_en, drv3_en;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    logic [7:0] model_q = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    rail_ctl_i2c dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .rail1_en(rail1_en), .rail4_en(rail4_en), .rail4_hi(rail4_hi), .rail5_en(rail5_en),
        .drv1_en(drv1_en), .drv2_en(drv2_en), .drv3_en(drv3_en)
    );

    function automatic logic [7:0] got_byte();
        return {rail1_en, rail4_en, rail4_hi, rail5_en, drv1_en, drv2_en, drv3_en, 1'b0};
    endfunction

    function automatic logic [7:0] stored_of(input logic [7:0] d);
        return d & 8'hFE;
    endfunction

    function automatic logic addr_acks(input logic [7:0] a);
        return a == 8'h10;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    // Sends a byte, returns the ACK seen on the line; during the ACK high
    // phase the outputs must still hold the model value (R6).
    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = ~sda_line;
        chk("R6 hold during ack", got_byte(), model_q);
        wq(Q);
        scl_m = 1'b0; wq(Q);
        chk("R4 ack released", {7'b0, sda_oe}, 8'h00);
    endtask

    task automatic full_write(input logic [7:0] a, input logic [7:0] d, input string req);
        logic ak;
        bus_start();
        send_byte(a, ak);
        chk({req, " addr ack"}, {7'b0, ak}, {7'b0, addr_acks(a)});
        send_byte(d, ak);
        chk({req, " data ack"}, {7'b0, ak}, {7'b0, addr_acks(a)});
        bus_stop();
        if (addr_acks(a)) model_q = stored_of(d);
        chk({req, " outputs"}, got_byte(), model_q);
    endtask

    task automatic abort_write(input logic [7:0] d, input int nbits, input bit by_start);
        logic ak;
        bus_start();
        send_byte(8'h10, ak);
        chk("R2 addr ack before abort", {7'b0, ak}, 8'h01);
        for (int i = 7; i > 7 - nbits; i--) send_bit(d[i]);
        if (by_start) begin
            bus_start();
            bus_stop();
        end else begin
            bus_stop();
        end
        chk("R7 abort keeps outputs", got_byte(), model_q);
    endtask

    task automatic double_write(input logic [7:0] d0, input logic [7:0] d1);
        logic ak;
        bus_start();
        send_byte(8'h10, ak);
        send_byte(d0, ak);
        chk("R4 first data ack", {7'b0, ak}, 8'h01);
        model_q = stored_of(d0);
        send_byte(d1, ak);
        chk("R9 extra byte nack", {7'b0, ak}, 8'h00);
        bus_stop();
        chk("R9 extra byte not stored", got_byte(), model_q);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic ak;
        void'($urandom(32'h5A17));
        wq(5);
        rst_n = 1'b1;
        wq(2);
        chk("R1 reset outputs", got_byte(), 8'h00);
        chk("R1 reset sda_oe", {7'b0, sda_oe}, 8'h00);

        // Directed cases
        full_write(8'h10, 8'hFF, "R2 R5 all on");
        full_write(8'h10, 8'h20, "R5 high select only");
        full_write(8'h10, 8'h01, "R5 bit0 ignored");
        full_write(8'h10, 8'hA4, "R5 mixed");
        full_write(8'h12, 8'h55, "R3 wrong addr");
        full_write(8'h11, 8'h00, "R3 read bit");
        abort_write(8'h00, 4, 1'b0);
        abort_write(8'h5A, 7, 1'b1);
        // Repeated START mid-byte, then a complete write (R8)
        bus_start();
        send_byte(8'h10, ak);
        send_bit(1'b0); send_bit(1'b1);
        full_write(8'h10, 8'h1E, "R8 write after restart");
        double_write(8'hC0, 8'h3E);

        // Random mix
        for (int t = 0; t < NRAND; t++) begin
            int          kind;
            logic [7:0]  d;
            logic [7:0]  a;
            kind = int'($urandom % 5);
            d = 8'($urandom);
            case (kind)
                0, 1: full_write(8'h10, d, "R5 random write");
                2: begin
                    a = 8'($urandom);
                    if (a == 8'h10) a = 8'h90;
                    full_write(a, d, "R3 random addr");
                end
                3: abort_write(d, 1 + int'($urandom % 7), 1'($urandom));
                default: double_write(d, 8'($urandom));
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule